// File: doc/BRIEF.md
# Multi-Polynomial Byte-Wise CRC Engine

This block keeps a running CRC over a message that arrives one byte at a time. A control write selects one of three generator polynomials, one 8-bit and two 16-bit, and the bit order. In MSB-first order each byte is taken bit 7 first against the normal polynomial. In LSB-first order each byte is taken bit 0 first against the bit-reversed polynomial. A control write also clears the running value to zero, so a control write starts a new message.

Software writes the control word once and then writes the message bytes. The message may be any whole number of bytes. After each byte, software reads `crc_out`. The running value starts at zero and no final XOR is applied. Every byte is folded into the CRC in a single clock cycle by a fully unrolled eight-stage datapath that all polynomial and order combinations share.

Top module: `crc_unit`

## Requirements
- R1: After synchronous reset, `crc_out` reads 0000h and the configuration is the 8-bit polynomial in MSB-first order (control word 000b).
- R2: Control word encoding. Bits [1:0] select the polynomial: 00 = x^8+x^2+x+1, 01 = x^16+x^15+x^2+1, 10 = x^16+x^12+x^5+1, and 11 behaves as 10. Bit [2] selects the order: 0 = MSB-first, 1 = LSB-first.
- R3: A cycle with `ctrl_we` high makes `crc_out` read 0000h in the following cycle.
- R4: A cycle with `data_we` high and `ctrl_we` low makes `crc_out` show the updated CRC in the following cycle.
- R5: In MSB-first order, bit 7 of each byte is processed first against the normal polynomial. The ASCII string "123456789" gives F4h, FEE8h and 31C3h for polynomial codes 00, 01 and 10.
- R6: In LSB-first order, bit 0 of each byte is processed first against the bit-reversed polynomial. "123456789" gives BB3Dh for code 01 and 2189h for code 10.
- R7: While the 8-bit polynomial is selected, `crc_out[15:8]` reads zero.
- R8: When `ctrl_we` and `data_we` are high in the same cycle, the control write takes effect and the data byte is discarded. The next cycle reads 0000h, and later bytes use the new configuration.
- R9: In a cycle with neither write strobe, `crc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 3 | Control word: order in bit 2, polynomial code in bits 1:0 |
| data_we | input | 1 | Data byte write strobe |
| data_in | input | 8 | Data byte |
| crc_out | output | 16 | Current CRC value |

## Verification
The assertions check on every cycle that a control write clears the result, that a control write wins over a simultaneous byte, and that the value holds when no strobe is high. They also check that the upper byte stays zero under the 8-bit polynomial, and that a zero byte leaves a zero CRC at zero. Whether each polynomial and bit order produces the correct arithmetic can only be shown by the bench. The bench compares every byte result against an independent bit-serial model, checks the standard check values for "123456789", confirms that the reserved code behaves as the 16-bit polynomial it aliases, and confirms that configuration changes carry over into later bytes.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int BYTE_W   = 8;
    localparam int CRC_W    = 16;
    localparam int NARROW_W = 8;
    localparam int ALIGN_SH = CRC_W - NARROW_W;
    localparam int CFG_W    = 3;

    typedef enum logic [1:0] {
        SEL_C8   = 2'b00,
        SEL_C16A = 2'b01,
        SEL_C16B = 2'b10,
        SEL_ALIAS = 2'b11
    } poly_sel_e;

    typedef enum logic {
        ORD_MSB = 1'b0,
        ORD_LSB = 1'b1
    } bit_order_e;

    typedef struct packed {
        bit_order_e order;
        poly_sel_e  sel;
    } crc_cfg_t;

    localparam logic [CRC_W-1:0] POLY_C8   = 16'h0007;
    localparam logic [CRC_W-1:0] POLY_C16A = 16'h8005;
    localparam logic [CRC_W-1:0] POLY_C16B = 16'h1021;

    function automatic crc_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        crc_cfg_t c;
        c.order = bit_order_e'(w[2]);
        c.sel   = poly_sel_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic is_narrow(input crc_cfg_t c);
        return (c.sel == SEL_C8);
    endfunction

    function automatic logic [CRC_W-1:0] rev_bits(input logic [CRC_W-1:0] v,
                                                  input int unsigned width);
        logic [CRC_W-1:0] r;
        r = '0;
        for (int k = 0; k < CRC_W; k++) begin
            if (k < int'(width)) r[width-1-k] = v[k];
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] base_poly(input crc_cfg_t c);
        logic [CRC_W-1:0] p;
        unique case (c.sel)
            SEL_C8:   p = POLY_C8;
            SEL_C16A: p = POLY_C16A;
            default:  p = POLY_C16B;
        endcase
        return p;
    endfunction

    // Polynomial operand as the shift datapath sees it:
    // MSB-first narrow CRCs run left-aligned, LSB-first ones right-aligned.
    function automatic logic [CRC_W-1:0] stage_poly(input crc_cfg_t c);
        logic [CRC_W-1:0] p;
        p = base_poly(c);
        if (c.order == ORD_LSB) begin
            p = is_narrow(c) ? rev_bits(p, NARROW_W) : rev_bits(p, CRC_W);
        end else if (is_narrow(c)) begin
            p = p << ALIGN_SH;
        end
        return p;
    endfunction

    function automatic logic [CRC_W-1:0] result_mask(input crc_cfg_t c);
        return is_narrow(c) ? {{ALIGN_SH{1'b0}}, {NARROW_W{1'b1}}} : {CRC_W{1'b1}};
    endfunction

endpackage

// File: rtl/crc_cfg_reg.sv
module crc_cfg_reg
    import crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output crc_cfg_t         cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{order: ORD_MSB, sel: SEL_C8};
        end else if (we) begin
            cfg_q <= decode_cfg(wdata);
        end
    end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int CW = CRC_W
) (
    input  crc_cfg_t        cfg,
    input  logic [CW-1:0]   crc_in,
    input  logic [DW-1:0]   data,
    output logic [CW-1:0]   crc_next
);
    localparam int SH = CW - NARROW_W;

    logic          lsb_first;
    logic          narrow_msb;
    logic [CW-1:0] poly_op;
    logic [CW-1:0] chain [0:DW];

    assign lsb_first  = (cfg.order == ORD_LSB);
    assign narrow_msb = is_narrow(cfg) && !lsb_first;
    assign poly_op    = stage_poly(cfg);

    // Narrow MSB-first runs with the value parked in the top byte.
    assign chain[0] = narrow_msb ? (crc_in << SH) : crc_in;

    for (genvar i = 0; i < DW; i++) begin : g_stage
        logic          bit_in;
        logic          fb;
        logic [CW-1:0] shifted;

        assign bit_in  = lsb_first ? data[i] : data[DW-1-i];
        assign fb      = bit_in ^ (lsb_first ? chain[i][0] : chain[i][CW-1]);
        assign shifted = lsb_first ? (chain[i] >> 1) : (chain[i] << 1);
        assign chain[i+1] = shifted ^ (fb ? poly_op : '0);
    end

    assign crc_next = narrow_msb ? (chain[DW] >> SH) : chain[DW];
endmodule

// File: rtl/crc_result_reg.sv
module crc_result_reg
    import crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  crc_cfg_t         cfg,
    input  logic [CRC_W-1:0] nxt,
    output logic [CRC_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q <= '0;
        end else if (load) begin
            q <= nxt & result_mask(cfg);
        end
    end
endmodule

// File: rtl/crc_unit.sv
module crc_unit
    import crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [CFG_W-1:0] ctrl_wdata,
    input  logic             data_we,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0] crc_out
);
    crc_cfg_t         cfg_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    logic             byte_take;

    // A control write wins; the byte in the same cycle is dropped.
    assign byte_take = data_we && !ctrl_we;

    crc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .cfg_q (cfg_q)
    );

    crc_byte_step #(.DW(BYTE_W), .CW(CRC_W)) u_step (
        .cfg      (cfg_q),
        .crc_in   (crc_q),
        .data     (data_in),
        .crc_next (crc_nxt)
    );

    crc_result_reg u_res (
        .clk   (clk),
        .rst   (rst),
        .clear (ctrl_we),
        .load  (byte_take),
        .cfg   (cfg_q),
        .nxt   (crc_nxt),
        .q     (crc_q)
    );

    assign crc_out = crc_q;
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk
    import crc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctrl_we,
    input logic              data_we,
    input logic [BYTE_W-1:0] data_in,
    input logic [CRC_W-1:0]  crc_out,
    input crc_cfg_t          cfg_q
);
    assert_ctrl_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (crc_out == '0));

    assert_ctrl_beats_byte_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && data_we) |=> (crc_out == '0));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_we && !data_we) |=> $stable(crc_out));

    assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.sel == SEL_C8) |-> (crc_out[CRC_W-1:NARROW_W] == '0));

    assert_zero_byte_zero_crc_R4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !ctrl_we && data_in == '0 && crc_out == '0) |=> (crc_out == '0));
endmodule

bind crc_unit crc_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (ctrl_we),
    .data_we (data_we),
    .data_in (data_in),
    .crc_out (crc_out),
    .cfg_q   (cfg_q)
);

// File: tb/crc_unit_bench.sv
`timescale 1ns/1ps
module crc_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_wdata = 3'b000;
    logic        data_we = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] crc_out;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] m_crc = 16'h0000;
    logic [2:0]  m_cfg = 3'b000;
    bit          done = 1'b0;
    string       msg = "123456789";

    always #2 clk = ~clk;

    crc_unit u_crc_unit (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .data_we    (data_we),
        .data_in    (data_in),
        .crc_out    (crc_out)
    );

    // Bit-serial reference built from the requirement text.
    function automatic logic [15:0] ref_byte(input logic [15:0] c,
                                             input logic [7:0] b,
                                             input logic [2:0] cfg);
        int          w;
        logic [15:0] p;
        logic [15:0] rp;
        logic [15:0] mask;
        logic        fb;
        w    = (cfg[1:0] == 2'b00) ? 8 : 16;
        p    = (cfg[1:0] == 2'b00) ? 16'h0007 :
               (cfg[1:0] == 2'b01) ? 16'h8005 : 16'h1021;
        mask = (w == 8) ? 16'h00FF : 16'hFFFF;
        rp   = 16'h0000;
        for (int k = 0; k < w; k++) rp[w-1-k] = p[k];
        if (cfg[2]) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ b[k];
                c  = c >> 1;
                if (fb) c = c ^ rp;
            end
        end else begin
            for (int k = 7; k >= 0; k--) begin
                fb = c[w-1] ^ b[k];
                c  = (c << 1) & mask;
                if (fb) c = c ^ p;
            end
        end
        return c & mask;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_ctrl(input logic [2:0] w);
        @(negedge clk); #1;
        ctrl_we = 1'b1; data_we = 1'b0; ctrl_wdata = w;
        m_cfg = w; m_crc = 16'h0000;
        sb_q.push_back('{exp: 16'h0000, tag: "R3"});
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        @(negedge clk); #1;
        ctrl_we = 1'b0; data_we = 1'b1; data_in = b;
        m_crc = ref_byte(m_crc, b, m_cfg);
        sb_q.push_back('{exp: m_crc, tag: tag});
    endtask

    task automatic send_both(input logic [2:0] w, input logic [7:0] b);
        @(negedge clk); #1;
        ctrl_we = 1'b1; data_we = 1'b1; ctrl_wdata = w; data_in = b;
        m_cfg = w; m_crc = 16'h0000;
        sb_q.push_back('{exp: 16'h0000, tag: "R8"});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            ctrl_we = 1'b0; data_we = 1'b0;
        end
    endtask

    task automatic send_msg(input string tag);
        for (int i = 0; i < msg.len(); i++) send_byte(msg[i], tag);
        idle(1);
    endtask

    // Monitor: results of the write clocked at the previous edge.
    always @(negedge clk) begin
        if (!rst && (ctrl_we || data_we)) begin
            if (sb_q.size() == 0) begin
                check(crc_out, 16'hxxxx, "R4 scoreboard empty");
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(crc_out, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold;
        logic [7:0]  lfsr;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(crc_out, 16'h0000, "R1 reset value");

        // R1 default configuration: 8-bit, MSB-first without a control write
        send_msg("R5 default cfg");
        check(crc_out, 16'h00F4, "R1 R5 default check value");

        // R9 hold
        hold = crc_out;
        idle(4);
        check(crc_out, hold, "R9 hold idle");

        // R5 MSB-first check values
        send_ctrl(3'b001); send_msg("R5 poly01 msb");
        check(crc_out, 16'hFEE8, "R5 poly01 msb");
        send_ctrl(3'b010); send_msg("R5 poly10 msb");
        check(crc_out, 16'h31C3, "R5 poly10 msb");
        send_ctrl(3'b000); send_msg("R7 poly00 msb");
        check(crc_out, 16'h00F4, "R5 poly00 msb");
        check({8'h00, crc_out[15:8]}, 16'h0000, "R7 upper byte msb");

        // R6 LSB-first check values
        send_ctrl(3'b101); send_msg("R6 poly01 lsb");
        check(crc_out, 16'hBB3D, "R6 poly01 lsb");
        send_ctrl(3'b110); send_msg("R6 poly10 lsb");
        check(crc_out, 16'h2189, "R6 poly10 lsb");
        send_ctrl(3'b100); send_msg("R6 poly00 lsb");
        check({8'h00, crc_out[15:8]}, 16'h0000, "R7 upper byte lsb");

        // R2 alias code 11 behaves as 10
        send_ctrl(3'b011); send_msg("R2 alias msb");
        check(crc_out, 16'h31C3, "R2 alias msb");
        send_ctrl(3'b111); send_msg("R2 alias lsb");
        check(crc_out, 16'h2189, "R2 alias lsb");

        // R4 pseudo-random bytes in every mode, back to back
        lfsr = 8'hA5;
        for (int c = 0; c < 8; c++) begin
            send_ctrl(c[2:0]);
            for (int i = 0; i < 12; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                send_byte(lfsr, "R4 random byte");
            end
            send_byte(8'h00, "R4 zero byte");
            send_byte(8'hFF, "R4 ones byte");
        end
        idle(1);

        // R8 simultaneous write: control wins, new cfg used afterwards
        send_ctrl(3'b000);
        send_byte(8'h5A, "R4 before clash");
        send_both(3'b110, 8'h33);
        send_msg("R8 after clash");
        check(crc_out, 16'h2189, "R8 new cfg in effect");

        // R3 clear mid-message then continue
        send_byte(8'h11, "R4 pre clear");
        send_ctrl(3'b001);
        idle(1);
        check(crc_out, 16'h0000, "R3 cleared");
        send_msg("R4 after clear");
        check(crc_out, 16'hFEE8, "R3 restart value");

        idle(2);
        done = 1'b1;
        if (sb_q.size() != 0) check(16'(sb_q.size()), 16'h0000, "R4 scoreboard leftover");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule